// File: doc/BRIEF.md
# ADC Input Offset Calibration Controller

This block measures and then cancels the DC offset of a single ADC channel. When software or a timing system sends a calibration event, the controller raises a switch control that ties the analogue input to ground. It then throws away a fixed number of converted samples so that the converter pipeline and the input can settle. Next it averages a power-of-two window of grounded samples and keeps the result as the channel offset until the next event.

The stored offset is used in one of two ways, chosen by a mode input. In digital mode, each later sample has the offset subtracted, and the result saturates at the signed sample range. In analogue mode, samples pass through unchanged, and the negated offset drives the code of an external compensation DAC. That code is clipped to the DAC width and given in offset-binary form. While the input is grounded, the corrected stream is marked invalid, so calibration data never reaches downstream logic.

Top module: `ofs_cal_ctrl`

## Requirements
- R1: After reset, `gnd_sw_o`, `busy_o`, `done_o` and `out_valid_o` are 0 and `dac_code_o` is mid-scale (2048 for 12 bits). A calibration starts only when `cal_evt_i` is high in the idle state. Without an event, `gnd_sw_o` stays low whatever the sample stream does.
- R2: `gnd_sw_o` and `busy_o` go high on the clock edge that captures the event. They stay high until the calibration completes.
- R3: After a calibration starts, the first SETTLE_CNT samples with `adc_valid_i` high (default 16) are discarded and do not affect the offset.
- R4: The offset is the average of the next 2^AVG_LOG2 valid samples (default 64), rounded toward minus infinity (arithmetic right shift of the sum). Cycles with `adc_valid_i` low are not counted.
- R5: `done_o` is a one-cycle pulse on the edge that captures the last averaged sample. On that same edge the offset register updates and `busy_o` and `gnd_sw_o` fall.
- R6: An event that arrives while `busy_o` is high is ignored: it neither restarts nor extends the calibration.
- R7: `out_valid_o` is high one cycle after a sample with `adc_valid_i` high was presented, unless `gnd_sw_o` was high in that cycle. In that case it is low.
- R8: With `mode_ana_i` = 0, `out_data_o` equals the sample minus the stored offset, clamped to [-8192, 8191], one cycle after the sample.
- R9: With `mode_ana_i` = 1, `out_data_o` is the sample unchanged, one cycle later. `dac_code_o` is the negated offset, clamped to the signed 12-bit range [-2048, 2047], with its most significant bit inverted (offset binary). It is registered one cycle after the offset or mode changes.
- R10: With `mode_ana_i` = 0, `dac_code_o` returns to mid-scale (2048) one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cal_evt_i | input | 1 | Calibration request |
| mode_ana_i | input | 1 | 1 = analogue compensation, 0 = digital subtraction |
| adc_data_i | input | 14 | Two's complement ADC sample |
| adc_valid_i | input | 1 | Sample qualifier |
| gnd_sw_o | output | 1 | Ties the analogue input to ground |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dac_code_o | output | 12 | Offset-binary code for the compensation DAC |
| out_data_o | output | 14 | Corrected or passed-through sample |
| out_valid_o | output | 1 | Qualifier for `out_data_o` |

## Verification
The bench fills the settling window with large unrelated values. A design that counted settling samples, or counted cycles with the valid bit low, would therefore store a visibly wrong offset. One window averages -3 and -4 alternately. A logical shift, or division that truncates toward zero, would give an offset other than -4, and a zero input would then not correct to 4. Subtraction is driven past both rails, and the DAC code is driven past both clip limits, where a wrapping design would flip sign. A second event is sent in the middle of a calibration: a design that restarted on it would pulse `done_o` late, and one that let grounded samples through would raise `out_valid_o` while `gnd_sw_o` is high.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE   = 2'd0,
        CAL_SETTLE = 2'd1,
        CAL_ACCUM  = 2'd2
    } cal_state_e;

endpackage

// File: rtl/ofs_cal_seq.sv
// Calibration sequencer: event capture, settling discard, averaging window.
module ofs_cal_seq
    import ofs_cal_pkg::*;
#(
    parameter int SAMPLE_W   = 14,
    parameter int SETTLE_CNT = 16,
    parameter int AVG_LOG2   = 6
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       cal_evt_i,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    input  logic                       smp_vld_i,
    output logic                       gnd_sw_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic signed [SAMPLE_W-1:0] offset_o
);

    localparam int AVG_N   = 1 << AVG_LOG2;
    localparam int CNT_MAX = (SETTLE_CNT > AVG_N) ? SETTLE_CNT : AVG_N;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int ACC_W   = SAMPLE_W + AVG_LOG2;

    typedef struct packed {
        cal_state_e               state;
        logic [CNT_W-1:0]         cnt;
        logic signed [ACC_W-1:0]  acc;
        logic signed [SAMPLE_W-1:0] offset;
        logic                     done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic signed [ACC_W-1:0] acc_sum;

    always_comb begin
        acc_sum = seq_q.acc + ACC_W'(smp_i);
        seq_d = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            CAL_IDLE: begin
                if (cal_evt_i) begin
                    seq_d.state = CAL_SETTLE;
                    seq_d.cnt   = '0;
                end
            end
            CAL_SETTLE: begin
                if (smp_vld_i) begin
                    if (seq_q.cnt == CNT_W'(SETTLE_CNT - 1)) begin
                        seq_d.state = CAL_ACCUM;
                        seq_d.cnt   = '0;
                        seq_d.acc   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            CAL_ACCUM: begin
                if (smp_vld_i) begin
                    seq_d.acc = acc_sum;
                    if (seq_q.cnt == CNT_W'(AVG_N - 1)) begin
                        seq_d.offset = SAMPLE_W'(acc_sum >>> AVG_LOG2);
                        seq_d.done   = 1'b1;
                        seq_d.state  = CAL_IDLE;
                        seq_d.cnt    = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: seq_d.state = CAL_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q.state  <= CAL_IDLE;
            seq_q.cnt    <= '0;
            seq_q.acc    <= '0;
            seq_q.offset <= '0;
            seq_q.done   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign gnd_sw_o = (seq_q.state != CAL_IDLE);
    assign busy_o   = (seq_q.state != CAL_IDLE);
    assign done_o   = seq_q.done;
    assign offset_o = seq_q.offset;

    // R1: leaving idle needs an event on the previous cycle
    assert_start_on_event_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(cal_evt_i));

    // R5: completion is a single-cycle pulse
    assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5: completion closes an active calibration
    assert_done_ends_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    // R4: completion only follows a valid averaged sample
    assert_done_on_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(smp_vld_i));

    // R6: a new event during averaging never sends the sequencer back
    assert_evt_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == CAL_ACCUM && cal_evt_i) |=> (seq_q.state != CAL_SETTLE));

endmodule

// File: rtl/ofs_cal_corr.sv
// Sample path: saturating subtraction or passthrough, blanked while grounded.
module ofs_cal_corr #(
    parameter int SAMPLE_W = 14
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    input  logic                       smp_vld_i,
    input  logic                       gnd_i,
    input  logic                       mode_ana_i,
    input  logic signed [SAMPLE_W-1:0] offset_i,
    output logic signed [SAMPLE_W-1:0] data_o,
    output logic                       valid_o
);

    localparam logic signed [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] data;
        logic                       valid;
    } corr_t;

    corr_t corr_d, corr_q;
    logic signed [SAMPLE_W:0]   diff;
    logic signed [SAMPLE_W-1:0] sat;

    always_comb begin
        diff = (SAMPLE_W+1)'(smp_i) - (SAMPLE_W+1)'(offset_i);
        if (diff[SAMPLE_W] != diff[SAMPLE_W-1]) begin
            sat = diff[SAMPLE_W] ? S_MIN : S_MAX;
        end else begin
            sat = diff[SAMPLE_W-1:0];
        end
        corr_d.valid = smp_vld_i && !gnd_i;
        corr_d.data  = mode_ana_i ? smp_i : sat;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            corr_q.data  <= '0;
            corr_q.valid <= 1'b0;
        end else begin
            corr_q <= corr_d;
        end
    end

    assign data_o  = corr_q.data;
    assign valid_o = corr_q.valid;

    // R7: no grounded sample is ever marked valid downstream
    assert_no_leak_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnd_i |=> !valid_o);

    // R9: analogue mode leaves the sample untouched
    assert_ana_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && mode_ana_i && !gnd_i) |=> (data_o == $past(smp_i)));

    // R8: zero offset in digital mode is an identity
    assert_dig_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && !mode_ana_i && !gnd_i && offset_i == '0) |=> (data_o == $past(smp_i)));

endmodule

// File: rtl/ofs_cal_dac.sv
// Compensation DAC code: negated offset, clipped, offset-binary.
module ofs_cal_dac #(
    parameter int SAMPLE_W = 14,
    parameter int DAC_W    = 12
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       mode_ana_i,
    input  logic signed [SAMPLE_W-1:0] offset_i,
    output logic [DAC_W-1:0]           dac_o
);

    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    typedef struct packed {
        logic [DAC_W-1:0] code;
    } dac_t;

    dac_t dac_d, dac_q;
    logic signed [SAMPLE_W:0] neg;
    logic signed [DAC_W-1:0]  clip;

    assign neg = -((SAMPLE_W+1)'(offset_i));

    generate
        if (DAC_W > SAMPLE_W) begin : g_wide
            assign clip = DAC_W'(neg);
        end else begin : g_clip
            localparam logic signed [SAMPLE_W:0] D_MAX = (SAMPLE_W+1)'((2 ** (DAC_W - 1)) - 1);
            localparam logic signed [SAMPLE_W:0] D_MIN = -D_MAX - 1;
            always_comb begin
                if (neg > D_MAX) begin
                    clip = {1'b0, {(DAC_W-1){1'b1}}};
                end else if (neg < D_MIN) begin
                    clip = {1'b1, {(DAC_W-1){1'b0}}};
                end else begin
                    clip = neg[DAC_W-1:0];
                end
            end
        end
    endgenerate

    always_comb begin
        dac_d.code = mode_ana_i ? {~clip[DAC_W-1], clip[DAC_W-2:0]} : MID;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dac_q.code <= MID;
        end else begin
            dac_q <= dac_d;
        end
    end

    assign dac_o = dac_q.code;

    // R10: digital mode parks the DAC at mid-scale
    assert_dac_mid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!mode_ana_i) |-> (dac_o == MID));

    // R9: zero offset in analogue mode gives mid-scale as well
    assert_dac_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mode_ana_i && offset_i == '0) |-> (dac_o == MID));

endmodule

// File: rtl/ofs_cal_ctrl.sv
// Top: offset calibration controller for one ADC channel.
module ofs_cal_ctrl #(
    parameter int SAMPLE_W   = 14,
    parameter int DAC_W      = 12,
    parameter int SETTLE_CNT = 16,
    parameter int AVG_LOG2   = 6
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       cal_evt_i,
    input  logic                       mode_ana_i,
    input  logic signed [SAMPLE_W-1:0] adc_data_i,
    input  logic                       adc_valid_i,
    output logic                       gnd_sw_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [DAC_W-1:0]           dac_code_o,
    output logic signed [SAMPLE_W-1:0] out_data_o,
    output logic                       out_valid_o
);

    logic signed [SAMPLE_W-1:0] offset_q;
    logic                       gnd_sw;

    ofs_cal_seq #(
        .SAMPLE_W  (SAMPLE_W),
        .SETTLE_CNT(SETTLE_CNT),
        .AVG_LOG2  (AVG_LOG2)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cal_evt_i(cal_evt_i),
        .smp_i    (adc_data_i),
        .smp_vld_i(adc_valid_i),
        .gnd_sw_o (gnd_sw),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .offset_o (offset_q)
    );

    ofs_cal_corr #(
        .SAMPLE_W(SAMPLE_W)
    ) u_corr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .smp_i     (adc_data_i),
        .smp_vld_i (adc_valid_i),
        .gnd_i     (gnd_sw),
        .mode_ana_i(mode_ana_i),
        .offset_i  (offset_q),
        .data_o    (out_data_o),
        .valid_o   (out_valid_o)
    );

    ofs_cal_dac #(
        .SAMPLE_W(SAMPLE_W),
        .DAC_W   (DAC_W)
    ) u_dac (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .mode_ana_i(mode_ana_i),
        .offset_i  (offset_q),
        .dac_o     (dac_code_o)
    );

    assign gnd_sw_o = gnd_sw;

    // R2: the ground switch stays up until completion
    assert_gnd_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnd_sw_o && !done_o) |=> (gnd_sw_o || done_o));

endmodule

// File: tb/ofs_cal_ctrl_test.sv
module ofs_cal_ctrl_test;

    localparam int SETTLE = 16;
    localparam int AVG    = 64;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cal_evt;
    logic               mode_ana;
    logic signed [13:0] adc_data;
    logic               adc_valid;
    logic               gnd_sw;
    logic               busy;
    logic               done;
    logic [11:0]        dac_code;
    logic signed [13:0] out_data;
    logic               out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ofs_cal_ctrl uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cal_evt_i  (cal_evt),
        .mode_ana_i (mode_ana),
        .adc_data_i (adc_data),
        .adc_valid_i(adc_valid),
        .gnd_sw_o   (gnd_sw),
        .busy_o     (busy),
        .done_o     (done),
        .dac_code_o (dac_code),
        .out_data_o (out_data),
        .out_valid_o(out_valid)
    );

    // {mode, sample, expected output} with a stored offset of 100
    localparam int VEC [9][3] = '{
        '{0,     0,  -100},   // R8 plain subtraction
        '{0,   100,     0},   // R8
        '{0, -8192, -8192},   // R8 lower rail
        '{0, -8150, -8192},   // R8 saturates low
        '{0, -8092, -8192},   // R8 exact boundary
        '{0,  8191,  8091},   // R8 top input
        '{1,  8191,  8191},   // R9 passthrough
        '{1, -8192, -8192},   // R9
        '{1,    37,    37}    // R9
    };

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_chk(string req, bit mode, int smp, int exp);
        @(negedge clk);
        mode_ana  = mode;
        adc_valid = 1'b1;
        adc_data  = 14'(smp);
        @(negedge clk);
        check(req, "out_valid", int'(out_valid), 1);
        check(req, "out_data", int'(out_data), exp);
        adc_valid = 1'b0;
    endtask

    task automatic do_cal(int settle_val, int v_even, int v_odd, bit gaps, bit reevt);
        int leak = 0;
        int early = 0;
        int lowbusy = 0;
        @(negedge clk);
        cal_evt   = 1'b1;
        adc_valid = 1'b0;
        @(negedge clk);
        cal_evt = 1'b0;
        check("R2", "gnd_sw after event", int'(gnd_sw), 1);
        check("R2", "busy after event", int'(busy), 1);
        for (int i = 0; i < SETTLE + AVG; i++) begin
            adc_valid = 1'b1;
            adc_data  = 14'((i < SETTLE) ? settle_val : (((i - SETTLE) % 2 == 0) ? v_even : v_odd));
            cal_evt   = reevt && (i == 20);
            @(negedge clk);
            cal_evt = 1'b0;
            if (out_valid) leak++;
            if (i != SETTLE + AVG - 1) begin
                if (done) early++;
                if (!busy || !gnd_sw) lowbusy++;
                if (gaps) begin
                    adc_valid = 1'b0;
                    adc_data  = 14'(3333);
                    @(negedge clk);
                    if (done) early++;
                    if (out_valid) leak++;
                end
            end
        end
        check("R5", "done at last sample", int'(done), 1);
        check("R5", "busy dropped", int'(busy), 0);
        check("R5", "gnd_sw dropped", int'(gnd_sw), 0);
        adc_valid = 1'b0;
        @(negedge clk);
        check("R5", "done one cycle", int'(done), 0);
        check("R7", "valid leaks while grounded", leak, 0);
        check(reevt ? "R6" : "R3", "early done", early, 0);
        check("R2", "busy or gnd low mid-run", lowbusy, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int gnd_seen = 0;
        rst_n     = 1'b0;
        cal_evt   = 1'b0;
        mode_ana  = 1'b0;
        adc_data  = '0;
        adc_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset gnd_sw", int'(gnd_sw), 0);
        check("R1", "reset busy", int'(busy), 0);
        check("R1", "reset done", int'(done), 0);
        check("R1", "reset out_valid", int'(out_valid), 0);
        check("R1", "reset dac", int'(dac_code), 2048);

        // R1: samples without an event never start a calibration
        for (int i = 0; i < 20; i++) begin
            adc_valid = 1'b1;
            adc_data  = 14'(1234);
            @(negedge clk);
            if (gnd_sw || busy) gnd_seen++;
        end
        check("R1", "no self start", gnd_seen, 0);
        check("R8", "zero offset output", int'(out_data), 1234);
        adc_valid = 1'b0;

        // Offset 100, junk settle values, event repeated mid-run
        do_cal(7777, 100, 100, 1'b0, 1'b1);
        for (int v = 0; v < 9; v++) begin
            drive_chk(VEC[v][0] != 0 ? "R9" : "R8", VEC[v][0] != 0, VEC[v][1], VEC[v][2]);
        end
        @(negedge clk);
        check("R9", "dac for offset 100", int'(dac_code), 1948);
        mode_ana = 1'b0;
        @(negedge clk);
        check("R10", "dac mid in digital", int'(dac_code), 2048);
        adc_valid = 1'b0;
        @(negedge clk);
        check("R7", "invalid sample not forwarded", int'(out_valid), 0);

        // R4: invalid cycles carry junk, offset -3000
        do_cal(-7000, -3000, -3000, 1'b1, 1'b0);
        drive_chk("R8", 1'b0, 8000, 8191);
        drive_chk("R8", 1'b0, -8192, -5192);
        mode_ana = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "dac clipped high", int'(dac_code), 4095);
        mode_ana = 1'b0;

        // R4: mean -3.5 floors to -4
        do_cal(-5000, -3, -4, 1'b0, 1'b0);
        drive_chk("R4", 1'b0, 0, 4);

        // R9: offset 3000 clips the DAC at its low end
        do_cal(0, 3000, 3000, 1'b0, 1'b0);
        mode_ana = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "dac clipped low", int'(dac_code), 0);
        drive_chk("R9", 1'b1, 123, 123);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule